// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the control core of an out-of-order execution engine. It keeps dynamic scheduling state for five functional units. There is one integer/load unit, two multipliers, one adder/subtractor and one divider, and they share a file of 16 registers. Decoded instructions arrive one per cycle over a valid/ready handshake. Each instruction is issued in program order to a free unit of the right kind. The block then tracks the instruction through four stages: issue, operand read, execution complete and result write. It raises a per-unit grant in each stage.

Each unit keeps its destination and source register numbers, the tags of the units that will produce its sources, and a ready flag per source. For each register, a result table names the unit that will write it next. Tag 0 means no pending writer. The execution datapaths are reduced to fixed-latency counters. Operands are never forwarded: a dependent read waits until the producer's write-back has happened. A write-back is held while any other unit still has to read the old value of the destination register.

Top module: `scb_top`

## Requirements
- R1: After reset no unit is busy. All grant vectors (`readVec`, `doneVec`, `writeVec`) are zero, and `inRdy` is high for any operation.
- R2: Operation encodings are: 0 load (integer unit, tag 1), 1 multiply (tags 2 and 3), 2 add and 3 subtract (tag 4), 4 divide (tag 5). An instruction issues when `inVld` and `inRdy` are both high. At most one instruction issues per cycle, in program order. It goes to the lowest-numbered free unit of its kind, and `issueUnit` reports that tag.
- R3: `inRdy` is low while every unit of the required kind is busy. A unit stays busy up to and including its write-back cycle, so the earliest issue to it is the following cycle.
- R4: `inRdy` is low while an issued instruction that has not yet written back targets the same destination register.
- R5: A unit reads its operands (bit set in `readVec` for one cycle) only once both sources are available. A source produced by another unit becomes available in the cycle after that unit's write-back.
- R6: The bit in `doneVec` pulses exactly L cycles after the read cycle, with L = 1 for the integer unit, 10 for multiply, 2 for add/subtract and 40 for divide.
- R7: A unit writes back (bit set in `writeVec`) no earlier than the cycle after its done pulse. It is held while another unit has not yet read a source that equals this unit's destination and whose value is already available (WAR).
- R8: A write-back frees the unit and the destination's result entry in the same cycle. A load with no hazards spans exactly four cycles from issue to write.
- R9: An instruction that issues in the same cycle as its source's producer writes back treats that source as available, and reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | Decoded instruction present |
| inRdy | output | 1 | Instruction can issue this cycle |
| inOp | input | 3 | Operation code |
| inDst | input | 4 | Destination register |
| inSrc1 | input | 4 | First source register |
| inSrc2 | input | 4 | Second source register |
| issueUnit | output | 3 | Tag of the unit that receives the instruction on a handshake |
| readVec | output | 5 | Per-unit operand read grant (bit = tag - 1) |
| doneVec | output | 5 | Per-unit execution complete pulse |
| writeVec | output | 5 | Per-unit result write-back grant |

## Verification
The hardest case to reach from the ports is a WAR hold. It needs a later short instruction that overwrites a register which an older long instruction has not yet read. The older instruction must itself be stalled on an unrelated RAW dependence. The stimulus gets there with a load, load, multiply, subtract, divide, add stream, where the add finishes long before the divide can read. A second stream does three things: it exercises the WAW stall, it issues a consumer exactly in its producer's write-back cycle by holding the instruction until the producer completes, and it occupies both multipliers. A behavioural per-instruction model predicts every grant in every cycle.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam int NUM_FU = 5;
  localparam int TAG_W  = 3;

  localparam logic [2:0] OP_LOAD = 3'd0;
  localparam logic [2:0] OP_MUL  = 3'd1;
  localparam logic [2:0] OP_ADD  = 3'd2;
  localparam logic [2:0] OP_SUB  = 3'd3;
  localparam logic [2:0] OP_DIV  = 3'd4;

  typedef enum logic [1:0] {KIND_INT, KIND_MUL, KIND_ADD, KIND_DIV} fuKind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_RD, ST_EXEC, ST_WAIT_WR} fuStage_e;

  typedef struct packed {
    logic              issueEn;
    logic [TAG_W-1:0]  issueTag;
    logic [TAG_W-1:0]  issueQj;
    logic [TAG_W-1:0]  issueQk;
    logic [NUM_FU-1:0] readVec;
    logic [NUM_FU-1:0] doneVec;
    logic [NUM_FU-1:0] writeVec;
  } ctrlStrb_t;

  function automatic fuKind_e opKind(input logic [2:0] op);
    case (op)
      OP_MUL:         return KIND_MUL;
      OP_ADD, OP_SUB: return KIND_ADD;
      OP_DIV:         return KIND_DIV;
      default:        return KIND_INT;
    endcase
  endfunction

  function automatic fuKind_e unitKind(input int idx);
    case (idx)
      0:       return KIND_INT;
      1, 2:    return KIND_MUL;
      3:       return KIND_ADD;
      default: return KIND_DIV;
    endcase
  endfunction

endpackage

// File: rtl/scb_unit_table.sv
module scb_unit_table
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int CNT_W    = 6,
  parameter int LAT_INT  = 1,
  parameter int LAT_MUL  = 10,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrc1,
  input  logic [REG_W-1:0] inSrc2,
  output logic             busy   [NUM_FU],
  output fuStage_e         stage  [NUM_FU],
  output logic [REG_W-1:0] fi     [NUM_FU],
  output logic [REG_W-1:0] fj     [NUM_FU],
  output logic [REG_W-1:0] fk     [NUM_FU],
  output logic             rj     [NUM_FU],
  output logic             rk     [NUM_FU],
  output logic [CNT_W-1:0] cnt    [NUM_FU],
  output logic [TAG_W-1:0] resTag [NUM_REGS]
);

  for (genvar g = 0; g < NUM_FU; g++) begin : gUnit
    localparam int LAT = (unitKind(g) == KIND_INT) ? LAT_INT :
                         (unitKind(g) == KIND_MUL) ? LAT_MUL :
                         (unitKind(g) == KIND_ADD) ? LAT_ADD : LAT_DIV;
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(g + 1);

    fuStage_e         stR;
    logic [REG_W-1:0] fiR, fjR, fkR;
    logic [TAG_W-1:0] qjR, qkR;
    logic             rjR, rkR;
    logic [CNT_W-1:0] cntR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stR  <= ST_IDLE;
        fiR  <= '0;
        fjR  <= '0;
        fkR  <= '0;
        qjR  <= '0;
        qkR  <= '0;
        rjR  <= 1'b0;
        rkR  <= 1'b0;
        cntR <= '0;
      end else if (strb.issueEn && strb.issueTag == MY_TAG) begin
        stR <= ST_WAIT_RD;
        fiR <= inDst;
        fjR <= inSrc1;
        fkR <= inSrc2;
        qjR <= strb.issueQj;
        qkR <= strb.issueQk;
        rjR <= (strb.issueQj == '0);
        rkR <= (strb.issueQk == '0);
      end else begin
        if (strb.readVec[g]) begin
          rjR  <= 1'b0;
          rkR  <= 1'b0;
          stR  <= ST_EXEC;
          cntR <= CNT_W'(LAT);
        end
        if (stR == ST_EXEC) begin
          cntR <= cntR - CNT_W'(1);
          if (strb.doneVec[g]) stR <= ST_WAIT_WR;
        end
        if (strb.writeVec[g]) stR <= ST_IDLE;
        for (int w = 0; w < NUM_FU; w++) begin
          if (strb.writeVec[w] && qjR == TAG_W'(w + 1)) begin
            rjR <= 1'b1;
            qjR <= '0;
          end
          if (strb.writeVec[w] && qkR == TAG_W'(w + 1)) begin
            rkR <= 1'b1;
            qkR <= '0;
          end
        end
      end
    end

    assign busy[g]  = (stR != ST_IDLE);
    assign stage[g] = stR;
    assign fi[g]    = fiR;
    assign fj[g]    = fjR;
    assign fk[g]    = fkR;
    assign rj[g]    = rjR;
    assign rk[g]    = rkR;
    assign cnt[g]   = cntR;

    AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (strb.issueEn && strb.issueTag == MY_TAG) |-> (stR == ST_IDLE)); // R3
    AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      strb.readVec[g] |=> !strb.readVec[g]); // R5
    AST_DONE_TO_WB: assert property (@(posedge clk) disable iff (!rstN)
      strb.doneVec[g] |=> (stR == ST_WAIT_WR)); // R6
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
      strb.writeVec[g] |=> (stR == ST_IDLE)); // R8
    AST_WB_CLEARS_DEST: assert property (@(posedge clk) disable iff (!rstN)
      strb.writeVec[g] |=> (resTag[$past(fiR)] != MY_TAG)); // R8
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) resTag[r] <= '0;
    end else begin
      for (int w = 0; w < NUM_FU; w++) begin
        if (strb.writeVec[w]) resTag[fi[w]] <= '0;
      end
      if (strb.issueEn) resTag[inDst] <= strb.issueTag;
    end
  end

  AST_NO_WAW_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueEn |-> (resTag[inDst] == '0)); // R4

endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 4,
  parameter int CNT_W    = 6
) (
  input  logic             inVld,
  input  logic [2:0]       inOp,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrc1,
  input  logic [REG_W-1:0] inSrc2,
  input  logic             busy   [NUM_FU],
  input  fuStage_e         stage  [NUM_FU],
  input  logic [REG_W-1:0] fi     [NUM_FU],
  input  logic [REG_W-1:0] fj     [NUM_FU],
  input  logic [REG_W-1:0] fk     [NUM_FU],
  input  logic             rj     [NUM_FU],
  input  logic             rk     [NUM_FU],
  input  logic [CNT_W-1:0] cnt    [NUM_FU],
  input  logic [TAG_W-1:0] resTag [NUM_REGS],
  output logic             inRdy,
  output ctrlStrb_t        strb
);

  fuKind_e          needKind;
  logic             unitFound;
  logic             wawHit;
  logic             warClear;
  logic [TAG_W-1:0] pickTag;
  logic [TAG_W-1:0] qjNew, qkNew;
  logic [NUM_FU-1:0] readV, doneV, writeV;

  always_comb begin
    needKind  = opKind(inOp);
    unitFound = 1'b0;
    pickTag   = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (!unitFound && unitKind(i) == needKind && !busy[i]) begin
        unitFound = 1'b1;
        pickTag   = TAG_W'(i + 1);
      end
    end
    wawHit = (resTag[inDst] != '0);
    inRdy  = unitFound && !wawHit;

    readV  = '0;
    doneV  = '0;
    writeV = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      readV[i] = (stage[i] == ST_WAIT_RD) && rj[i] && rk[i];
      doneV[i] = (stage[i] == ST_EXEC) && (cnt[i] == CNT_W'(1));
      warClear = 1'b1;
      for (int j = 0; j < NUM_FU; j++) begin
        if (j != i) begin
          if ((rj[j] && fj[j] == fi[i]) || (rk[j] && fk[j] == fi[i])) warClear = 1'b0;
        end
      end
      writeV[i] = (stage[i] == ST_WAIT_WR) && warClear;
    end

    qjNew = resTag[inSrc1];
    qkNew = resTag[inSrc2];
    for (int w = 0; w < NUM_FU; w++) begin
      if (writeV[w] && resTag[inSrc1] == TAG_W'(w + 1)) qjNew = '0;
      if (writeV[w] && resTag[inSrc2] == TAG_W'(w + 1)) qkNew = '0;
    end

    strb.issueEn  = inVld && inRdy;
    strb.issueTag = pickTag;
    strb.issueQj  = qjNew;
    strb.issueQk  = qkNew;
    strb.readVec  = readV;
    strb.doneVec  = doneV;
    strb.writeVec = writeV;
  end

endmodule

// File: rtl/scb_top.sv
module scb_top
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_MUL  = 10,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 40,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  output logic              inRdy,
  input  logic [2:0]        inOp,
  input  logic [REG_W-1:0]  inDst,
  input  logic [REG_W-1:0]  inSrc1,
  input  logic [REG_W-1:0]  inSrc2,
  output logic [TAG_W-1:0]  issueUnit,
  output logic [NUM_FU-1:0] readVec,
  output logic [NUM_FU-1:0] doneVec,
  output logic [NUM_FU-1:0] writeVec
);

  ctrlStrb_t        strb;
  logic             busy   [NUM_FU];
  fuStage_e         stage  [NUM_FU];
  logic [REG_W-1:0] fi     [NUM_FU];
  logic [REG_W-1:0] fj     [NUM_FU];
  logic [REG_W-1:0] fk     [NUM_FU];
  logic             rj     [NUM_FU];
  logic             rk     [NUM_FU];
  logic [CNT_W-1:0] cnt    [NUM_FU];
  logic [TAG_W-1:0] resTag [NUM_REGS];

  scb_ctrl #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) uCtrl (
    .inVld(inVld), .inOp(inOp), .inDst(inDst), .inSrc1(inSrc1), .inSrc2(inSrc2),
    .busy(busy), .stage(stage), .fi(fi), .fj(fj), .fk(fk), .rj(rj), .rk(rk),
    .cnt(cnt), .resTag(resTag), .inRdy(inRdy), .strb(strb)
  );

  scb_unit_table #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W),
    .LAT_INT(LAT_INT), .LAT_MUL(LAT_MUL), .LAT_ADD(LAT_ADD), .LAT_DIV(LAT_DIV)
  ) uTable (
    .clk(clk), .rstN(rstN), .strb(strb), .inDst(inDst), .inSrc1(inSrc1), .inSrc2(inSrc2),
    .busy(busy), .stage(stage), .fi(fi), .fj(fj), .fk(fk), .rj(rj), .rk(rk),
    .cnt(cnt), .resTag(resTag)
  );

  assign issueUnit = strb.issueTag;
  assign readVec   = strb.readVec;
  assign doneVec   = strb.doneVec;
  assign writeVec  = strb.writeVec;

endmodule

// File: tb/tb_scb_top.sv
`timescale 1ns/1ps
module tb_scb_top;

  localparam int MAXN = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inVld;
  logic       inRdy;
  logic [2:0] inOp;
  logic [3:0] inDst, inSrc1, inSrc2;
  logic [2:0] issueUnit;
  logic [4:0] readVec, doneVec, writeVec;

  always #2 clk = ~clk;

  scb_top dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy), .inOp(inOp),
    .inDst(inDst), .inSrc1(inSrc1), .inSrc2(inSrc2), .issueUnit(issueUnit),
    .readVec(readVec), .doneVec(doneVec), .writeVec(writeVec)
  );

  int checks = 0;
  int errors = 0;

  int n = 0;
  int pOp[MAXN], pDst[MAXN], pS1[MAXN], pS2[MAXN], gKind[MAXN], gRef[MAXN];
  int iss[MAXN], rd[MAXN], dn[MAXN], wr[MAXN], unitOf[MAXN], p1[MAXN], p2[MAXN];
  int cyc = 0;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0d expected %0d", req, cyc, got, exp);
    end
  endtask

  task automatic addInstr(input int op, input int d, input int s1, input int s2,
                          input int gk, input int gr);
    pOp[n] = op; pDst[n] = d; pS1[n] = s1; pS2[n] = s2; gKind[n] = gk; gRef[n] = gr;
    iss[n] = -1; rd[n] = -1; dn[n] = -1; wr[n] = -1; unitOf[n] = 0; p1[n] = -1; p2[n] = -1;
    n++;
  endtask

  function automatic int latOf(input int op);
    case (op)
      0: return 1;
      1: return 10;
      2, 3: return 2;
      default: return 40;
    endcase
  endfunction

  function automatic bit tagFits(input int op, input int tag);
    case (op)
      0: return tag == 1;
      1: return tag == 2 || tag == 3;
      2, 3: return tag == 4;
      default: return tag == 5;
    endcase
  endfunction

  function automatic bit srcReady(input int m, input int which);
    int p;
    p = (which == 1) ? p1[m] : p2[m];
    return p < 0 || (wr[p] >= 0 && wr[p] < cyc);
  endfunction

  function automatic bit pending(input int k);
    return iss[k] >= 0 && !(wr[k] >= 0 && wr[k] < cyc);
  endfunction

  function automatic bit warBlocked(input int k);
    for (int m = 0; m < n; m++) begin
      if (m != k && iss[m] >= 0 && rd[m] < 0) begin
        if ((pS1[m] == pDst[k] && srcReady(m, 1)) || (pS2[m] == pDst[k] && srcReady(m, 2)))
          return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic bit gateOk(input int h);
    if (gKind[h] == 1) begin
      for (int k = 0; k < h; k++) if (!(wr[k] >= 0 && wr[k] < cyc)) return 1'b0;
      return 1'b1;
    end
    if (gKind[h] == 2) return dn[gRef[h]] >= 0 && cyc >= dn[gRef[h]] + 1;
    return 1'b1;
  endfunction

  function automatic bit allWritten();
    for (int k = 0; k < n; k++) if (wr[k] < 0) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    int head;
    bit present, expRdy, ok;
    int expTag;
    int eRd, eDn, eWr;
    bit doRd[MAXN], doDn[MAXN], doWr[MAXN];

    rstN = 1'b0; inVld = 1'b0; inOp = 3'd0; inDst = 4'd0; inSrc1 = 4'd0; inSrc2 = 4'd0;

    // Stream 1: WAR case (add 5 overwrites r6 that divide 4 still has to read)
    addInstr(0, 6, 15, 15, 0, 0);
    addInstr(0, 2, 15, 15, 0, 0);
    addInstr(1, 0, 2, 4, 0, 0);
    addInstr(3, 8, 6, 2, 0, 0);
    addInstr(4, 10, 0, 6, 0, 0);
    addInstr(2, 6, 8, 2, 0, 0);
    // Stream 2: both multipliers, WAW on r1, same-cycle producer write at issue
    addInstr(1, 1, 14, 14, 1, 0);
    addInstr(1, 2, 14, 14, 0, 0);
    addInstr(2, 1, 2, 3, 0, 0);
    addInstr(4, 4, 1, 1, 0, 0);
    addInstr(0, 9, 14, 14, 0, 0);
    addInstr(3, 11, 9, 9, 2, 10);

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R2: idle state after reset, unit selection per operation code
    @(negedge clk);
    #1;
    chk("R1 readVec idle", int'(readVec), 0);
    chk("R1 doneVec idle", int'(doneVec), 0);
    chk("R1 writeVec idle", int'(writeVec), 0);
    for (int op = 0; op < 5; op++) begin
      inOp = 3'(op);
      #1;
      chk("R1 inRdy idle", int'(inRdy), 1);
      chk("R2 unit for op", int'(issueUnit), (op == 0) ? 1 : (op == 1) ? 2 : (op == 4) ? 5 : 4);
    end

    head = 0;
    cyc = 0;
    while (!allWritten() && cyc < 3000) begin
      @(negedge clk);
      present = (head < n) && gateOk(head);
      inVld = present;
      if (head < n) begin
        inOp = 3'(pOp[head]); inDst = 4'(pDst[head]);
        inSrc1 = 4'(pS1[head]); inSrc2 = 4'(pS2[head]);
      end
      #1;
      eRd = 0; eDn = 0; eWr = 0;
      for (int k = 0; k < n; k++) begin
        doRd[k] = 0; doDn[k] = 0; doWr[k] = 0;
        if (iss[k] >= 0) begin
          if (rd[k] < 0 && srcReady(k, 1) && srcReady(k, 2)) doRd[k] = 1;
          if (rd[k] >= 0 && dn[k] < 0 && rd[k] + latOf(pOp[k]) == cyc) doDn[k] = 1;
          if (dn[k] >= 0 && wr[k] < 0 && !warBlocked(k)) doWr[k] = 1;
          if (doRd[k]) eRd |= 1 << (unitOf[k] - 1);
          if (doDn[k]) eDn |= 1 << (unitOf[k] - 1);
          if (doWr[k]) eWr |= 1 << (unitOf[k] - 1);
        end
      end
      expRdy = 0; expTag = 0;
      if (head < n) begin
        for (int t = 1; t <= 5; t++) begin
          ok = tagFits(pOp[head], t);
          for (int k = 0; k < n; k++) if (pending(k) && unitOf[k] == t) ok = 0;
          if (ok && expTag == 0) expTag = t;
        end
        expRdy = (expTag != 0);
        for (int k = 0; k < head; k++) if (pending(k) && pDst[k] == pDst[head]) expRdy = 0;
        if (present) chk("R2 R3 R4 inRdy", int'(inRdy), int'(expRdy));
        if (present && expRdy) chk("R2 issueUnit", int'(issueUnit), expTag);
      end
      chk("R5 readVec", int'(readVec), eRd);
      chk("R6 doneVec", int'(doneVec), eDn);
      chk("R7 writeVec", int'(writeVec), eWr);
      for (int k = 0; k < n; k++) begin
        if (doRd[k]) rd[k] = cyc;
        if (doDn[k]) dn[k] = cyc;
        if (doWr[k]) wr[k] = cyc;
      end
      if (present && expRdy) begin
        iss[head] = cyc; unitOf[head] = expTag;
        for (int k = 0; k < head; k++) begin
          if (pDst[k] == pS1[head]) p1[head] = k;
          if (pDst[k] == pS2[head]) p2[head] = k;
        end
        head++;
      end
      cyc++;
    end

    if (!allWritten()) begin
      errors++;
      $display("FAIL watchdog: instructions still pending at cycle %0d", cyc);
    end else begin
      chk("R8 load four-cycle span", wr[0] - iss[0], 3);
      chk("R8 first load write cycle", wr[0], 3);
      chk("R3 second load waits for unit", iss[1], 4);
      chk("R5 multiply reads after r2 write", rd[2], wr[1] + 1);
      chk("R6 multiply latency", dn[2] - rd[2], 10);
      chk("R6 divide latency", dn[4] - rd[4], 40);
      chk("R6 subtract latency", dn[3] - rd[3], 2);
      chk("R7 add held by WAR", int'(wr[5] > dn[5] + 1), 1);
      chk("R7 add writes after divide read", wr[5], rd[4] + 1);
      chk("R2 second multiplier used", unitOf[7], 3);
      chk("R4 WAW issue after write", iss[8], wr[6] + 1);
      chk("R9 issue in producer write cycle", iss[11], wr[10]);
      chk("R9 read next cycle", rd[11], wr[10] + 1);
      for (int k = 1; k < n; k++) chk("R2 program order", int'(iss[k] > iss[k-1]), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule